// File: doc/BRIEF.md
# Radio Baseband Register Port Master

This block lets on-chip logic read and write the registers of an external radio baseband over a three-wire serial link with a select line. A single command carries a 7-bit register address, 8 bits of write data and a read/write flag. The block then runs one framed transfer. An active-low select opens the frame. A serial clock, divided down from the system clock, times each bit. A strobe line is high while address bits are on the shared data wire and low while data bits are on it. A direction line holds the read/write flag for the whole frame.

The shared data wire is modelled as three plain ports: an output value, an output enable and an input value. The pad or the bench resolves them. Outgoing bits, the strobe and the direction change only when the serial clock falls. Incoming bits are sampled when it rises. A read returns its 8 captured bits together with a one-cycle done pulse. New commands are refused while a frame is open.

Top module: `radio_reg_port`

## Requirements
- R1: Out of reset the select is high, the serial clock is low, and busy, done and the data-line enable are all low.
- R2: A command is taken only while busy is low. A command offered during a frame leaves that frame unchanged and does not start a second one.
- R3: For a divide value D, the serial clock is high for floor(D/2) and low for ceil(D/2) system cycles. A divide input below 2 selects D = 14. D is captured when the command is taken, and later changes to the divide input do not affect the current frame.
- R4: The select goes low ceil(D/2) cycles before the first rising serial clock edge. It returns high ceil(D/2) cycles after the last falling edge.
- R5: Each frame has 15 rising edges. Edges 1 to 7 carry the address MSB first with the strobe high. Edges 8 to 15 carry data MSB first with the strobe low.
- R6: The strobe, direction and outgoing data value stay stable while the serial clock is high.
- R7: The direction line is 1 for a read and 0 for a write, and it holds that value while the select is low.
- R8: On a write the data-line enable is high for the whole time the select is low, and the 8 data bits are driven out.
- R9: On a read the enable is high for the address phase and drops at the falling edge after the seventh address bit. The read data output then holds the 8 bits sampled on rising edges 8 to 15, MSB first.
- R10: Busy is high from the cycle after acceptance until the select returns high. Done pulses for exactly one cycle, in the cycle the select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, taken when busy is low |
| cmd_rnw_i | input | 1 | 1 = register read, 0 = register write |
| cmd_addr_i | input | 7 | Register address |
| cmd_wdata_i | input | 8 | Write data |
| div_i | input | 8 | Serial clock divide; below 2 selects 14 |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 8 | Data captured by the last read |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Active-low select |
| strobe_o | output | 1 | High during address bits, low during data bits |
| rnw_o | output | 1 | Direction of the current frame |
| sd_o | output | 1 | Outgoing data bit |
| sd_oe_o | output | 1 | Drive enable for the data wire |
| sd_i | input | 1 | Incoming data bit from the wire |

## Verification
The hardest case to reach is a command that arrives while a frame is open, together with a divide change in the middle of that frame. Both must leave the frame untouched. The bench starts a write with a short divide. Several bits in, it offers a read to a different address with a different divide. It then checks that the captured address, data, direction and clock half-periods all belong to the first command, and that the select stays high after done. The read-turnaround edge is reached by a bench model of the baseband. That model drives response bits on each falling edge after the seventh rise, with the minimum divide of 2 as the tightest case.

// File: rtl/radio_port_pkg.sv
package radio_port_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } port_state_e;
endpackage

// File: rtl/rp_div_cfg.sv
module rp_div_cfg #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 14
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] lo_len_o,
  output logic [DIV_W-1:0] hi_len_o
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W:0]   eff_ext;

  assign eff      = (div_i < DIV_W'(2)) ? DIV_W'(DEF_DIV) : div_i;
  assign eff_ext  = {1'b0, eff} + (DIV_W+1)'(1);
  assign lo_len_o = eff_ext[DIV_W:1];
  assign hi_len_o = {1'b0, eff[DIV_W-1:1]};
endmodule

// File: rtl/rp_half_timer.sv
module rp_half_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q == W'(1));
endmodule

// File: rtl/rp_shift_reg.sv
module rp_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         in_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (load_i)   q_o <= load_val_i;
    else if (shift_i)  q_o <= {q_o[W-2:0], in_i};
  end
endmodule

// File: rtl/radio_reg_port.sv
module radio_reg_port
  import radio_port_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_rnw_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              strobe_o,
  output logic              rnw_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(ADDR_W);

  port_state_e      state_q, state_n;
  logic [DIV_W-1:0] div_q, div_sel, lo_len, hi_len, tmr_len;
  logic [CNT_W-1:0] bit_q;
  logic             rnw_q, done_q, active, accept, expire, tmr_load;
  logic             fall_ev, rise_ev, data_phase, last_bit;
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q, rdata_q;

  assign active     = (state_q != ST_IDLE);
  assign accept     = cmd_valid_i && !active;
  assign data_phase = (bit_q >= FIRST_DATA);
  assign last_bit   = (bit_q == LAST_BIT);
  assign fall_ev    = (state_q == ST_HIGH) && expire;
  assign rise_ev    = ((state_q == ST_LOW) || (state_q == ST_LEAD)) && expire;

  // divide captured at acceptance, live input only on that cycle
  assign div_sel = accept ? div_i : div_q;

  rp_div_cfg #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_div_cfg (
    .div_i    (div_sel),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_n = ST_LEAD;
      ST_LEAD: if (expire) state_n = ST_HIGH;
      ST_HIGH: if (expire) state_n = last_bit ? ST_TAIL : ST_LOW;
      ST_LOW:  if (expire) state_n = ST_HIGH;
      ST_TAIL: if (expire) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign tmr_load = accept || (expire && (state_n != ST_IDLE));
  assign tmr_len  = (state_n == ST_HIGH) ? hi_len : lo_len;

  rp_half_timer #(.W(DIV_W)) i_half_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (expire)
  );

  rp_shift_reg #(.W(FRAME_W)) i_tx_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i ({cmd_addr_i, cmd_wdata_i}),
    .shift_i    (fall_ev && !last_bit),
    .in_i       (1'b0),
    .q_o        (tx_q)
  );

  rp_shift_reg #(.W(DATA_W)) i_rx_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i ('0),
    .shift_i    (rise_ev && rnw_q && data_phase),
    .in_i       (sd_i),
    .q_o        (rx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      rnw_q   <= 1'b0;
      bit_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= (state_q == ST_TAIL) && expire;
      if (accept) begin
        div_q <= div_i;
        rnw_q <= cmd_rnw_i;
        bit_q <= '0;
      end else if (fall_ev && !last_bit) begin
        bit_q <= bit_q + CNT_W'(1);
      end
      if ((state_q == ST_TAIL) && expire && rnw_q) rdata_q <= rx_q;
    end
  end

  assign busy_o   = active;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign cs_no    = !active;
  assign sclk_o   = (state_q == ST_HIGH);
  assign strobe_o = active && !data_phase;
  assign rnw_o    = active && rnw_q;
  assign sd_o     = active && tx_q[FRAME_W-1];
  assign sd_oe_o  = active && !(rnw_q && data_phase);

  // R1
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R4
  lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (!cs_no && !$past(cs_no)));
  // R6
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> ($stable(strobe_o) && $stable(sd_o) && $stable(rnw_o)));
  // R7
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no)) |-> $stable(rnw_o));
  // R8
  write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !rnw_o) |-> sd_oe_o);
  // R10
  done_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o && !$past(cs_no)));
endmodule

// File: tb/test_radio_reg_port.sv
`timescale 1ns/1ps
module test_radio_reg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_rnw = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0, div = '0;
  logic       busy, done, sclk, cs_n, strobe, rnw, sd, sd_oe;
  logic       sd_in = 1'b0;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  radio_reg_port i_radio_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_rnw_i(cmd_rnw),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .div_i(div),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .sclk_o(sclk), .cs_no(cs_n),
    .strobe_o(strobe), .rnw_o(rnw), .sd_o(sd), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // baseband model and frame monitor, sampled on the falling system edge
  int rises, run, lead_m, tail_m, hi_min, hi_max, lo_min, lo_max;
  int strobe_err, oe_err, stab_err, busy_err, done_cnt, done_bad;
  logic [6:0] addr_cap;
  logic [7:0] data_cap, resp;
  logic rnw_seen, p_sclk = 1'b0, p_cs = 1'b1, p_strobe = 1'b0, p_sd = 1'b0, p_rnw = 1'b0;

  task automatic clear_mon();
    rises = 0; run = 0; lead_m = -1; tail_m = -1;
    hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
    strobe_err = 0; oe_err = 0; stab_err = 0; busy_err = 0;
    done_cnt = 0; done_bad = 0; addr_cap = '0; data_cap = '0; rnw_seen = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        rises = 0; run = 1;
      end else if (!p_sclk && sclk) begin
        if (rises == 0) lead_m = run;
        else begin
          if (run < lo_min) lo_min = run;
          if (run > lo_max) lo_max = run;
        end
        if (rises < 7) addr_cap = {addr_cap[5:0], sd};
        else if (!rnw) data_cap = {data_cap[6:0], sd};
        if (strobe != (rises < 7)) strobe_err++;
        if (sd_oe != !(rnw && rises >= 7)) oe_err++;
        rnw_seen = rnw;
        rises++; run = 1;
      end else if (p_sclk && !sclk) begin
        if (run < hi_min) hi_min = run;
        if (run > hi_max) hi_max = run;
        if (rnw && rises >= 7 && rises < 15) sd_in = resp[14-rises];
        run = 1;
      end else if (!p_cs && cs_n) begin
        tail_m = run; run = 1;
      end else begin
        run++;
      end
      if (p_sclk && sclk && (strobe != p_strobe || sd != p_sd || rnw != p_rnw)) stab_err++;
      if (!cs_n && !busy) busy_err++;
      if (done) begin
        done_cnt++;
        if (!cs_n) done_bad++;
      end
    end
    p_sclk = sclk; p_cs = cs_n; p_strobe = strobe; p_sd = sd; p_rnw = rnw;
  end

  task automatic issue(input bit r, input logic [6:0] a, input logic [7:0] w, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rnw = r; cmd_addr = a; cmd_wdata = w; div = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input bit r, input logic [6:0] a, input logic [7:0] w,
                             input int d_eff, input logic [7:0] rv);
    int lo, hi;
    lo = (d_eff + 1) / 2;
    hi = d_eff / 2;
    chk(rises == 15, "R5 rising edges", rises, 15);
    chk(addr_cap == a, "R5 address bits", addr_cap, a);
    chk(strobe_err == 0, "R5 strobe phase", strobe_err, 0);
    chk(stab_err == 0, "R6 stable while clock high", stab_err, 0);
    chk(rnw_seen == r, "R7 direction", rnw_seen, r);
    chk(lead_m == lo, "R4 select lead", lead_m, lo);
    chk(tail_m == lo, "R4 select tail", tail_m, lo);
    chk(hi_min == hi && hi_max == hi, "R3 high half", hi_max, hi);
    chk(lo_min == lo && lo_max == lo, "R3 low half", lo_max, lo);
    chk(done_cnt == 1 && done_bad == 0, "R10 done pulse", done_cnt, 1);
    chk(busy == 1'b0 && busy_err == 0, "R10 busy span", busy_err, 0);
    if (r) begin
      chk(oe_err == 0, "R9 enable turnaround", oe_err, 0);
      chk(rdata == rv, "R9 read data", rdata, rv);
    end else begin
      chk(oe_err == 0, "R8 write enable", oe_err, 0);
      chk(data_cap == w, "R8 write data", data_cap, w);
    end
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset lines", {cs_n, sclk}, 2);
    chk(busy == 1'b0 && done == 1'b0 && sd_oe == 1'b0, "R1 reset flags", {busy, done, sd_oe}, 0);
  endtask

  task automatic t_write_default();
    clear_mon(); resp = 8'h00;
    issue(1'b0, 7'h55, 8'hA3, 8'd0);
    wait_done();
    check_frame(1'b0, 7'h55, 8'hA3, 14, 8'h00);
  endtask

  task automatic t_read_odd();
    clear_mon(); resp = 8'h96;
    issue(1'b1, 7'h0B, 8'hFF, 8'd5);
    wait_done();
    check_frame(1'b1, 7'h0B, 8'hFF, 5, 8'h96);
  endtask

  task automatic t_read_min_div();
    clear_mon(); resp = 8'h01;
    issue(1'b1, 7'h7F, 8'h00, 8'd2);
    wait_done();
    check_frame(1'b1, 7'h7F, 8'h00, 2, 8'h01);
  endtask

  task automatic t_div_one_default();
    clear_mon(); resp = 8'h00;
    issue(1'b0, 7'h00, 8'h81, 8'd1);
    wait_done();
    check_frame(1'b0, 7'h00, 8'h81, 14, 8'h00);
  endtask

  task automatic t_busy_ignore();
    clear_mon(); resp = 8'hC3;
    issue(1'b0, 7'h2A, 8'h5C, 8'd4);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_rnw = 1'b1; cmd_addr = 7'h11; div = 8'd9;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    // R2 second command must not alter the frame; R3 divide latched at acceptance
    check_frame(1'b0, 7'h2A, 8'h5C, 4, 8'h00);
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1 && rises == 15, "R2 no second frame", rises, 15);
    chk(rdata == 8'h96 || rdata == 8'h01, "R2 read data untouched", rdata, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    clear_mon();
    resp = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_default();
    t_read_odd();
    t_read_min_div();
    t_div_one_default();
    t_busy_ignore();
    finish_run();
  end
endmodule